// File: doc/BRIEF.md
# Tiered Interrupt Request Aggregator

This block gathers event pulses from the parts of a two-port network switch and folds them into a single active-high interrupt request for the host CPU. Leaf sources are grouped into banks. The switch-fabric path has three tiers of pending/mask pairs: sub-module banks, a fabric-level summary, and the top level. The timestamp path uses one combined status/enable register. Both paths meet in a top-level status word with a matching enable word. A configuration word carries the global output enable that gates the pin.

The CPU reads and writes every register through a plain port. It has a write strobe, a word address, write data and combinationally read data. Leaf pending bits latch a one-cycle source pulse and stay set until the CPU writes a one to them. Every summary bit above the leaves is recomputed from the enabled bits below it. A summary bit therefore drops as soon as the leaf bits under it are cleared.

Top module: `hier_irq_ctrl`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: A one-cycle high on a source input sets its leaf pending bit at the next clock edge. The bit stays set until it is cleared by the CPU.
- R3: Writing 1 to a leaf pending bit clears it, and writing 0 leaves it unchanged. If a source pulse and a clear land in the same cycle, the bit stays set.
- R4: The timestamp register sits at address 3. Status bits [8:0] are write-1-to-clear and enable bits [24:16] are read/write. Both fields use the same source order from bit 0 upward: port0 TX, port0 RX, port1 TX, port1 RX, port2 TX, port2 RX, GPIO8 capture, GPIO9 capture, timer (`ts_evt_i` uses this order too).
- R5: The buffer-manager pending register is at address 6 (bit 0 = Status A, bit 1 = Status B) and its mask is at address 7. The switch-engine pending register is at address 8 (bit 0) and its mask is at address 9. A mask bit of 1 enables its source.
- R6: The fabric pending word at address 4 is read-only. Bit 0 is the OR of the enabled buffer-manager bits, bit 1 is the enabled switch-engine bit, and bits 4:2 (MAC ports 0..2) are always 0. The fabric mask at address 5 is read/write in bits [4:0].
- R7: The MAC pending/mask pairs at addresses 10..15 (pending then mask, for port 0, then port 1, then port 2) always read 0 and ignore writes.
- R8: The top status word at address 0 is read-only. Bit 29 is the OR of the enabled timestamp status bits. Bit 28 is the OR of fabric pending bits ANDed with the fabric mask. Writes to it have no effect.
- R9: The top enable word at address 1 keeps only bit 29 (timestamp) and bit 28 (fabric). Its other bits read 0.
- R10: `irq_o` is a register. It goes high one cycle after config bit 8 (address 2) is set together with an enabled top status bit (29 with enable 29, or 28 with enable 28).
- R11: `irq_o` falls one cycle after the last enabled condition is removed, whether by a clear, a mask, an enable or the output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_evt_i | input | 9 | Timestamp event pulses, order as R4 |
| bm_evt_i | input | 2 | Buffer-manager pulses: bit 0 Status A, bit 1 Status B |
| se_evt_i | input | 1 | Switch-engine interrupt pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, active high, level |

## Verification
A lost or stuck leaf bit shows up at the read port in the cycle after the pulse or clear. If the bit is enabled, it also shows on `irq_o` one cycle after that. A wrong mask, enable or summary term shows up as a top or fabric summary bit that disagrees with the leaves on the very next read. Within one further edge it also shows as an interrupt edge in the wrong cycle. The bench compares the read data and the pin against a behavioural model on every cycle, so a divergence is reported in the cycle it first appears.

// File: rtl/hier_irq_pkg.sv
package hier_irq_pkg;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int NUM_PORTS   = 3;
    localparam int TS_W        = 2 * NUM_PORTS + 3;
    localparam int BM_W        = 2;
    localparam int SE_W        = 1;
    localparam int FAB_W       = 2 + NUM_PORTS;

    localparam int TS_EN_LSB   = 16;
    localparam int TOP_TS_BIT  = 29;
    localparam int TOP_FAB_BIT = 28;
    localparam int OE_BIT      = 8;

    localparam logic [ADDR_W-1:0] A_TOP_STAT = 4'd0;
    localparam logic [ADDR_W-1:0] A_TOP_EN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CFG      = 4'd2;
    localparam logic [ADDR_W-1:0] A_TS       = 4'd3;
    localparam logic [ADDR_W-1:0] A_FAB_PEND = 4'd4;
    localparam logic [ADDR_W-1:0] A_FAB_MASK = 4'd5;
    localparam logic [ADDR_W-1:0] A_BM_PEND  = 4'd6;
    localparam logic [ADDR_W-1:0] A_BM_MASK  = 4'd7;
    localparam logic [ADDR_W-1:0] A_SE_PEND  = 4'd8;
    localparam logic [ADDR_W-1:0] A_SE_MASK  = 4'd9;
    localparam logic [ADDR_W-1:0] A_MAC_BASE = 4'd10;

    typedef struct packed {
        logic             irq;
        logic             oe;
        logic             en_ts;
        logic             en_fab;
        logic [FAB_W-1:0] fab_mask;
    } top_state_t;
endpackage

// File: rtl/hier_irq_leaf.sv
module hier_irq_leaf #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_bits_i,
    input  logic         en_we_i,
    input  logic [N-1:0] en_bits_i,
    output logic [N-1:0] pend_o,
    output logic [N-1:0] en_o,
    output logic         hit_o
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] en;
    } leaf_t;

    leaf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_we_i) begin
            st_d.en = en_bits_i;
        end
        st_d.pend = (st_q.pend & ~(clr_we_i ? clr_bits_i : '0)) | src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign hit_o  = |(st_q.pend & st_q.en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R2 / R3: a pulse always lands, even against a clear
        a_r2_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
            src_i[i] |=> pend_o[i]);
        a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we_i && clr_bits_i[i] && !src_i[i]) |=> !pend_o[i]);
        a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[i] && !(clr_we_i && clr_bits_i[i])) |=> pend_o[i]);
    end
endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
    import hier_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   ts_evt_i,
    input  logic [BM_W-1:0]   bm_evt_i,
    input  logic [SE_W-1:0]   se_evt_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    top_state_t st_d, st_q;

    logic [TS_W-1:0] ts_pend, ts_en;
    logic [BM_W-1:0] bm_pend, bm_en;
    logic [SE_W-1:0] se_pend, se_en;
    logic            ts_hit, bm_hit, se_hit, fab_hit;
    logic [FAB_W-1:0] fab_pend;

    logic wr_ts, wr_bm_p, wr_bm_m, wr_se_p, wr_se_m;

    assign wr_ts   = reg_we_i && (reg_addr_i == A_TS);
    assign wr_bm_p = reg_we_i && (reg_addr_i == A_BM_PEND);
    assign wr_bm_m = reg_we_i && (reg_addr_i == A_BM_MASK);
    assign wr_se_p = reg_we_i && (reg_addr_i == A_SE_PEND);
    assign wr_se_m = reg_we_i && (reg_addr_i == A_SE_MASK);

    hier_irq_leaf #(.N(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .src_i(ts_evt_i),
        .clr_we_i(wr_ts), .clr_bits_i(reg_wdata_i[TS_W-1:0]),
        .en_we_i(wr_ts), .en_bits_i(reg_wdata_i[TS_EN_LSB +: TS_W]),
        .pend_o(ts_pend), .en_o(ts_en), .hit_o(ts_hit)
    );

    hier_irq_leaf #(.N(BM_W)) u_bm (
        .clk(clk), .rst_n(rst_n), .src_i(bm_evt_i),
        .clr_we_i(wr_bm_p), .clr_bits_i(reg_wdata_i[BM_W-1:0]),
        .en_we_i(wr_bm_m), .en_bits_i(reg_wdata_i[BM_W-1:0]),
        .pend_o(bm_pend), .en_o(bm_en), .hit_o(bm_hit)
    );

    hier_irq_leaf #(.N(SE_W)) u_se (
        .clk(clk), .rst_n(rst_n), .src_i(se_evt_i),
        .clr_we_i(wr_se_p), .clr_bits_i(reg_wdata_i[SE_W-1:0]),
        .en_we_i(wr_se_m), .en_bits_i(reg_wdata_i[SE_W-1:0]),
        .pend_o(se_pend), .en_o(se_en), .hit_o(se_hit)
    );

    // Fabric summary: sub-module hits, MAC slots reserved at zero
    assign fab_pend[0] = bm_hit;
    assign fab_pend[1] = se_hit;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_mac
        assign fab_pend[2+p] = 1'b0;
    end
    assign fab_hit = |(fab_pend & st_q.fab_mask);

    always_comb begin
        st_d = st_q;
        if (reg_we_i) begin
            unique case (reg_addr_i)
                A_TOP_EN: begin
                    st_d.en_ts  = reg_wdata_i[TOP_TS_BIT];
                    st_d.en_fab = reg_wdata_i[TOP_FAB_BIT];
                end
                A_CFG:      st_d.oe       = reg_wdata_i[OE_BIT];
                A_FAB_MASK: st_d.fab_mask = reg_wdata_i[FAB_W-1:0];
                default: ;
            endcase
        end
        st_d.irq = st_q.oe && ((ts_hit && st_q.en_ts) || (fab_hit && st_q.en_fab));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            A_TOP_STAT: begin
                reg_rdata_o[TOP_TS_BIT]  = ts_hit;
                reg_rdata_o[TOP_FAB_BIT] = fab_hit;
            end
            A_TOP_EN: begin
                reg_rdata_o[TOP_TS_BIT]  = st_q.en_ts;
                reg_rdata_o[TOP_FAB_BIT] = st_q.en_fab;
            end
            A_CFG:      reg_rdata_o[OE_BIT] = st_q.oe;
            A_TS: begin
                reg_rdata_o[TS_W-1:0]            = ts_pend;
                reg_rdata_o[TS_EN_LSB +: TS_W]   = ts_en;
            end
            A_FAB_PEND: reg_rdata_o[FAB_W-1:0] = fab_pend;
            A_FAB_MASK: reg_rdata_o[FAB_W-1:0] = st_q.fab_mask;
            A_BM_PEND:  reg_rdata_o[BM_W-1:0]  = bm_pend;
            A_BM_MASK:  reg_rdata_o[BM_W-1:0]  = bm_en;
            A_SE_PEND:  reg_rdata_o[SE_W-1:0]  = se_pend;
            A_SE_MASK:  reg_rdata_o[SE_W-1:0]  = se_en;
            default:    reg_rdata_o = '0;
        endcase
    end

    assign irq_o = st_q.irq;

    // R10: the pin needs the output enable of the cycle before
    a_r10_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(st_q.oe));
    // R11: nothing enabled in a cycle means the pin is low in the next
    a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !((ts_hit && st_q.en_ts) || (fab_hit && st_q.en_fab)) |=> !irq_o);
    // R6: reserved MAC slots never report
    a_r6_mac_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fab_pend[FAB_W-1:2] == '0);
    // R8: fabric summary bit follows the sub-module hits through the mask
    a_r8_fab_needs_leaf: assert property (@(posedge clk) disable iff (!rst_n)
        fab_hit |-> (bm_hit || se_hit));
    // R7: MAC register window reads zero
    a_r7_mac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr_i >= A_MAC_BASE) |-> (reg_rdata_o == '0));
endmodule

// File: tb/hier_irq_ctrl_bench.sv
module hier_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  ts_evt = '0;
    logic [1:0]  bm_evt = '0;
    logic [0:0]  se_evt = '0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    hier_irq_ctrl u_hier_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ts_evt_i(ts_evt), .bm_evt_i(bm_evt),
        .se_evt_i(se_evt), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // Behavioural reference
    logic [8:0] m_tsp = '0, m_tse = '0;
    logic [1:0] m_bmp = '0, m_bme = '0;
    logic       m_sep = 1'b0, m_see = 1'b0;
    logic [4:0] m_fm = '0;
    logic       m_e29 = 1'b0, m_e28 = 1'b0, m_oe = 1'b0, m_irq = 1'b0;

    function automatic logic [4:0] fab_pend();
        logic [4:0] f = '0;
        f[0] = |(m_bmp & m_bme);
        f[1] = m_sep & m_see;
        return f;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r = '0;
        case (a)
            0: begin r[29] = |(m_tsp & m_tse); r[28] = |(fab_pend() & m_fm); end
            1: begin r[29] = m_e29; r[28] = m_e28; end
            2: r[8] = m_oe;
            3: begin r[8:0] = m_tsp; r[24:16] = m_tse; end
            4: r[4:0] = fab_pend();
            5: r[4:0] = m_fm;
            6: r[1:0] = m_bmp;
            7: r[1:0] = m_bme;
            8: r[0] = m_sep;
            9: r[0] = m_see;
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tsp <= '0; m_tse <= '0; m_bmp <= '0; m_bme <= '0;
            m_sep <= 1'b0; m_see <= 1'b0; m_fm <= '0;
            m_e29 <= 1'b0; m_e28 <= 1'b0; m_oe <= 1'b0; m_irq <= 1'b0;
        end else begin
            logic [31:0] top;
            logic [8:0]  tclr;
            logic [1:0]  bclr;
            logic        sclr;
            top  = model_read(4'd0);
            tclr = (we && addr == 3) ? wdata[8:0] : 9'd0;
            bclr = (we && addr == 6) ? wdata[1:0] : 2'd0;
            sclr = we && addr == 8 && wdata[0];
            m_irq <= m_oe && ((top[29] && m_e29) || (top[28] && m_e28));
            m_tsp <= (m_tsp & ~tclr) | ts_evt;
            m_bmp <= (m_bmp & ~bclr) | bm_evt;
            m_sep <= (m_sep & ~sclr) | se_evt[0];
            if (we) begin
                case (addr)
                    1: begin m_e29 <= wdata[29]; m_e28 <= wdata[28]; end
                    2: m_oe <= wdata[8];
                    3: m_tse <= wdata[24:16];
                    5: m_fm <= wdata[4:0];
                    7: m_bme <= wdata[1:0];
                    9: m_see <= wdata[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "rdata", rdata, model_read(addr));
            check(cur_req, "irq", {31'd0, irq}, {31'd0, m_irq});
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        step();
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a);
        addr = a;
        step();
    endtask

    initial begin
        step();
        cur_req = "R1";
        for (int a = 0; a < 16; a++) rd(a[3:0]);
        rst_n = 1'b1;
        for (int a = 0; a < 16; a++) rd(a[3:0]);
        check("R1", "irq after reset", {31'd0, irq}, 32'd0);

        cur_req = "R2";
        ts_evt = 9'h040; step(); ts_evt = '0;          // GPIO8 capture
        rd(3); rd(3);
        check("R2", "gpio8 sticky", rdata, 32'h0000_0040);
        check("R8", "disabled ts not summarised", model_read(0), 32'd0);

        cur_req = "R4";
        ts_evt = 9'h101; step(); ts_evt = '0;          // port0 TX + timer
        rd(3);
        wr(3, 32'h0040_0000);                           // enable GPIO8 only
        rd(0);
        cur_req = "R10";
        wr(1, 32'h2000_0000);
        rd(0); rd(0);
        check("R10", "oe off holds pin low", {31'd0, irq}, 32'd0);
        wr(2, 32'h0000_0100);
        rd(2);
        check("R10", "pin up", {31'd0, irq}, 32'd1);
        cur_req = "R8";
        wr(0, 32'hFFFF_FFFF);
        rd(0); rd(0);

        cur_req = "R3";
        wr(3, 32'h0040_0040);                           // clear GPIO8, keep enable
        cur_req = "R11";
        rd(3); rd(0); rd(0);
        check("R11", "pin down after clear", {31'd0, irq}, 32'd0);
        cur_req = "R3";
        ts_evt = 9'h004; we = 1'b1; addr = 3; wdata = 32'h0000_0004;
        step();
        we = 1'b0; ts_evt = '0;
        rd(3);
        check("R3", "set wins over clear", rdata & 32'h4, 32'h4);
        wr(3, 32'h0000_01FF);
        rd(3);

        cur_req = "R5";
        bm_evt = 2'b10; step(); bm_evt = '0;            // Status B
        rd(6); wr(7, 32'h2); rd(7);
        cur_req = "R6";
        rd(4); wr(5, 32'h1F); rd(5); rd(0);
        cur_req = "R9";
        wr(1, 32'hFFFF_FFFF); rd(1); rd(1); rd(0);
        cur_req = "R11";
        wr(7, 32'h0); rd(0); rd(0);
        wr(7, 32'h3); rd(0); rd(0);
        wr(2, 32'h0); rd(0); rd(0);
        wr(2, 32'h100); rd(0);
        wr(6, 32'h3); rd(0); rd(0);

        cur_req = "R5";
        se_evt = 1'b1; step(); se_evt = '0;
        rd(8); wr(9, 32'h1); rd(4); rd(0);
        cur_req = "R11";
        wr(5, 32'h1); rd(0); rd(0);
        wr(5, 32'h2); rd(0);
        wr(8, 32'h1); rd(8); rd(0);

        cur_req = "R7";
        for (int a = 10; a < 16; a++) begin
            wr(a[3:0], 32'hFFFF_FFFF);
            rd(a[3:0]);
        end
        rd(4);
        check("R7", "mac slots idle", rdata & 32'h1C, 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule